// File: doc/BRIEF.md
# Two-Wire Bus Command Receiver (Slave Side)

This block is the slave end of a two-wire serial bus (clock line SCL and open-drain data line SDA). It samples both lines with the system clock and finds start and stop conditions in the samples. It answers only to its own 8-bit device address. The upper six bits of that address are a parameter and the lower two bits come from pins strapped on the board, so up to four of these blocks can share one bus. Once the address matches, the block takes a command byte and then an optional data byte. It acknowledges the address and each byte it receives. It then hands the command, and the data byte if one came, to a register block through a single-cycle strobe.

The block pulls SDA low by raising `sda_oe`, and the pad turns this into an open-drain driver. A command whose bit 7 is set is a read. The block strobes that command out at once and takes `rd_data` one clock later. It then shifts that byte onto the bus, most significant bit first.

The controller has eleven states:
- `ST_IDLE` waits for a start.
- `ST_ADDR`, `ST_CMD` and `ST_DATA` receive a byte each.
- `ST_ADDR_ACK`, `ST_CMD_ACK` and `ST_DATA_ACK` drive an acknowledge.
- `ST_TX_LOAD` captures the read byte.
- `ST_TX` shifts the read byte out.
- `ST_TX_ACK` lets the master acknowledge.
- `ST_WAIT` stays silent until the next start or stop.

The transitions are:
- A start in any state goes to `ST_ADDR`.
- A stop in any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a full matching byte, or to `ST_WAIT` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_CMD`, and `ST_CMD` goes to `ST_CMD_ACK`.
- `ST_CMD_ACK` goes to `ST_TX_LOAD` for a read, or to `ST_DATA` for a write.
- `ST_DATA` goes to `ST_DATA_ACK`, and `ST_DATA_ACK` goes to `ST_WAIT`.
- `ST_TX_LOAD` goes to `ST_TX`, `ST_TX` goes to `ST_TX_ACK` after eight bits, and `ST_TX_ACK` goes to `ST_WAIT`.

Every byte-to-byte transition takes place on a falling SCL edge.

Top module: `twc_slave`

## Requirements
- R1: While `rst_n` is low, `sda_oe` and `cmd_valid` are 0.
- R2: Until a start condition (SDA falling while SCL is high) is seen, clocked bytes get no acknowledge and no strobe.
- R3: The first byte after a start is taken MSB first and matched against `{DEV_ID[5:0], addr_pins[1:0]}`.
  - On a match, `sda_oe` is 1 for the ninth SCL clock.
  - On a mismatch, `sda_oe` stays 0 for the rest of the frame, even if more bytes are clocked.
- R4: After a matching address, the command byte and the data byte that follows it are each acknowledged on their ninth SCL clock.
- R5: A write with a data byte raises `cmd_valid` for one cycle at the falling SCL edge that ends the data acknowledge. At that moment `has_data` is 1, and `cmd_byte` and `data_byte` carry the two bytes, received MSB first.
- R6: A write command followed by a stop (SDA rising while SCL is high) before a second data bit is clocked raises `cmd_valid` for one cycle at the stop, with `has_data` 0.
- R7: A command with bit 7 set is a read.
  - `cmd_valid` pulses at the end of its acknowledge, with `has_data` 0.
  - `rd_data` is sampled one clock later and sent MSB first; `sda_oe` equals the inverse of each bit.
  - After those eight bits and the master's acknowledge clock, SDA stays released until the next start.
- R8: A start inside a frame discards any partial byte and restarts address reception.
- R9: A stop inside a frame, before the final acknowledge, ends the frame with no strobe and with SDA released.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 2 | Strapped low bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | input | 8 | Byte to return for a read command |
| cmd_valid | output | 1 | One-cycle strobe for a received command |
| cmd_byte | output | 8 | Received command byte |
| data_byte | output | 8 | Received data byte, 0 when none |
| has_data | output | 1 | A data byte came with the command |

## Verification
The hardest cases to reach from the ports are frames that break off in the middle of a byte. One is a repeated start after a few command bits. The other is a stop a few bits into the data byte. To reach them, the bench's bus master has a task that clocks out only the leading bits of a byte and then issues the condition. The command-only case is also delicate, because the stop's own SCL rise shifts in a stray bit. A frame ended by a stop straight after the command acknowledge exercises that case. A bench model that tracks each cycle follows the synchronizer delay and compares `sda_oe` and the strobe at every clock.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int BYTE_W = 8;
    localparam int PIN_W  = 2;
    localparam int ID_W   = BYTE_W - PIN_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int TXC_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX_LOAD,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } twc_state_e;
endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // bus lines idle high, so the chain resets to 1
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/twc_cond.sv
module twc_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data moving while the clock stays high marks a frame boundary
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twc_rx_shift.sv
module twc_rx_shift #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_i,
    output logic [W-1:0]  byte_o,
    output logic [CW-1:0] cnt_o,
    output logic          full_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o  <= '0;
        end else if (shift_en && (cnt_o != FULL_CNT)) begin
            byte_o <= {byte_o[W-2:0], bit_i};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

    assign full_o = (cnt_o == FULL_CNT);
endmodule

// File: rtl/twc_slave.sv
module twc_slave
    import twc_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID      = 6'b010110,
    parameter int              SYNC_STAGES = 2,
    parameter int              RD_BIT      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_pins,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic [BYTE_W-1:0] data_byte,
    output logic              has_data
);
    localparam logic [TXC_W-1:0] TX_LAST = TXC_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CMD_ONLY_LIM = CNT_W'(2);

    // ---------------- line synchronizers ----------------
    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        twc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (sync_lines[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    // ---------------- bus condition detection ----------------
    logic scl_rise, scl_fall, start_evt, stop_evt;

    twc_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // ---------------- receive shifter ----------------
    twc_state_e        state, state_nxt;
    logic              rx_clr, rx_shift, rx_full;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  rx_cnt;
    logic              receiving, in_ack;

    assign receiving = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK);
    assign rx_clr    = start_evt || (scl_fall && in_ack);
    assign rx_shift  = scl_rise && receiving;

    twc_rx_shift #(.W(BYTE_W), .CW(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .shift_en (rx_shift),
        .bit_i    (sda_s),
        .byte_o   (rx_byte),
        .cnt_o    (rx_cnt),
        .full_o   (rx_full)
    );

    logic addr_ok;
    assign addr_ok = (rx_byte == {DEV_ID, addr_pins});

    // ---------------- command and transmit holding ----------------
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] tx_q;
    logic [TXC_W-1:0]  tx_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            tx_q   <= '1;
            tx_cnt <= '0;
        end else begin
            if ((state == ST_CMD) && scl_fall && rx_full) begin
                cmd_q <= rx_byte;
            end
            if (state == ST_TX_LOAD) begin
                tx_q   <= rd_data;
                tx_cnt <= '0;
            end else if ((state == ST_TX) && scl_fall) begin
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b1};
                tx_cnt <= tx_cnt + 1'b1;
            end
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        if (start_evt) begin
            state_nxt = ST_ADDR;
        end else if (stop_evt) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && rx_full) begin
                        state_nxt = addr_ok ? ST_ADDR_ACK : ST_WAIT;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_nxt = ST_CMD;
                end
                ST_CMD: begin
                    if (scl_fall && rx_full) state_nxt = ST_CMD_ACK;
                end
                ST_CMD_ACK: begin
                    if (scl_fall) state_nxt = cmd_q[RD_BIT] ? ST_TX_LOAD : ST_DATA;
                end
                ST_DATA: begin
                    if (scl_fall && rx_full) state_nxt = ST_DATA_ACK;
                end
                ST_DATA_ACK: begin
                    if (scl_fall) state_nxt = ST_WAIT;
                end
                ST_TX_LOAD: state_nxt = ST_TX;
                ST_TX: begin
                    if (scl_fall && (tx_cnt == TX_LAST)) state_nxt = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (scl_fall) state_nxt = ST_WAIT;
                end
                ST_WAIT: state_nxt = ST_WAIT;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sda_oe    = 1'b0;
        cmd_valid = 1'b0;
        has_data  = 1'b0;
        cmd_byte  = cmd_q;
        data_byte = '0;
        unique case (state)
            ST_ADDR_ACK: sda_oe = 1'b1;
            ST_CMD_ACK: begin
                sda_oe    = 1'b1;
                cmd_valid = scl_fall && cmd_q[RD_BIT];
            end
            ST_DATA: begin
                cmd_valid = stop_evt && (rx_cnt < CMD_ONLY_LIM);
            end
            ST_DATA_ACK: begin
                sda_oe    = 1'b1;
                has_data  = 1'b1;
                data_byte = rx_byte;
                cmd_valid = scl_fall;
            end
            ST_TX: sda_oe = ~tx_q[BYTE_W-1];
            default: ;
        endcase
    end
endmodule

// File: rtl/twc_checker.sv
module twc_checker
    import twc_pkg::*;
#(
    parameter int RD_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              cmd_valid,
    input logic              has_data,
    input logic [BYTE_W-1:0] cmd_byte,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input twc_state_e        state
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!sda_oe && !cmd_valid));

    // holds while each SCL phase outlasts the synchronizer delay
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR));

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_oe));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_strobe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (scl_fall || stop_evt));

    p_cmd_only_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !has_data && !cmd_byte[RD_BIT]) |-> stop_evt);
endmodule

bind twc_slave twc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .has_data  (has_data),
    .cmd_byte  (cmd_byte),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .state     (state)
);

// File: tb/twc_slave_tb_top.sv
module twc_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [5:0] ID = 6'b010110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] pins = 2'b10;
    logic [7:0] rd_data = 8'hA6;
    logic       sda_oe, cmd_valid, has_data;
    logic [7:0] cmd_byte, data_byte;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    twc_slave #(.DEV_ID(ID)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_pins (pins),
        .sda_oe    (sda_oe),
        .rd_data   (rd_data),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .data_byte (data_byte),
        .has_data  (has_data)
    );

    int checks = 0;
    int errors = 0;
    logic [16:0] seen[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference, stepped every clock ----------------
    logic [2:0] h_scl = '1;
    logic [2:0] h_sda = '1;
    always @(posedge clk) begin
        if (!rst_n) begin
            h_scl <= '1;
            h_sda <= '1;
        end else begin
            h_scl <= {h_scl[1:0], scl_m};
            h_sda <= {h_sda[1:0], sda_bus};
        end
    end

    int   ms = 0;
    int   mcnt = 0;
    int   mtxc = 0;
    logic [7:0] mbyte = 0, mcmd = 0, mtx = 8'hFF;
    logic prev_oe = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mtxc = 0; mtx = 8'hFF; prev_oe = 1'b0;
        end else begin
            bit rise, fall, st, sp, eoe, evld;
            rise = h_scl[1] & ~h_scl[2];
            fall = ~h_scl[1] & h_scl[2];
            st   = h_scl[1] & h_scl[2] & h_sda[2] & ~h_sda[1];
            sp   = h_scl[1] & h_scl[2] & ~h_sda[2] & h_sda[1];
            eoe  = (ms == 2 || ms == 4 || ms == 6 || (ms == 8 && !mtx[7]));
            evld = (ms == 6 && fall) || (ms == 5 && sp && mcnt <= 1) ||
                   (ms == 4 && fall && mcmd[7]);
            chk(sda_oe == eoe, "R4 cycle model sda_oe", sda_oe, eoe);
            chk(cmd_valid == evld, "R5 cycle model cmd_valid", cmd_valid, evld);
            if (sda_oe != prev_oe)
                chk(!scl_m, "R10 sda_oe moved with SCL high", scl_m, 0);
            prev_oe = sda_oe;
            if (cmd_valid) seen.push_back({has_data, cmd_byte, data_byte});
            if (st) begin
                ms = 1; mcnt = 0;
            end else if (sp) begin
                ms = 0;
            end else begin
                if ((ms == 1 || ms == 3 || ms == 5) && rise && mcnt < 8) begin
                    mbyte = {mbyte[6:0], h_sda[1]};
                    mcnt++;
                end
                case (ms)
                    1: if (fall && mcnt == 8) ms = (mbyte == {ID, pins}) ? 2 : 10;
                    2: if (fall) begin ms = 3; mcnt = 0; end
                    3: if (fall && mcnt == 8) begin mcmd = mbyte; ms = 4; end
                    4: if (fall) begin ms = mcmd[7] ? 7 : 5; mcnt = 0; end
                    5: if (fall && mcnt == 8) ms = 6;
                    6: if (fall) ms = 10;
                    7: begin mtx = rd_data; mtxc = 0; ms = 8; end
                    8: if (fall) begin
                           mtx = {mtx[6:0], 1'b1};
                           if (mtxc == 7) ms = 9;
                           mtxc++;
                       end
                    9: if (fall) ms = 10;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- bus master tasks ----------------
    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; hp();
            scl_m = 1'b1; hp();
        end
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hp();
            scl_m = 1'b1; hp();
            scl_m = 1'b0; hp();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        ack = !sda_bus;
        scl_m = 1'b0; hp();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hp();
            scl_m = 1'b1; hp();
            b[i] = sda_bus;
            scl_m = 1'b0; hp();
        end
        sda_m = !mack; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
        sda_m = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- directed frames ----------------
    initial begin
        bit a0, a1, a2;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        chk(!sda_oe && !cmd_valid, "R1 outputs in reset", {sda_oe, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sda_oe, "R1 released after reset", sda_oe, 0);

        // R2: a well-formed address byte with no start before it
        scl_m = 1'b0; hp();
        send_byte(8'h5A, a0);
        chk(!a0, "R2 ack without start", a0, 0);
        chk(seen.size() == 0, "R2 strobe without start", seen.size(), 0);

        // R4 / R5: full write
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h21, a1); send_byte(8'hC3, a2);
        bus_stop();
        chk(a0, "R3 address ack", a0, 1);
        chk(a1 && a2, "R4 command and data ack", {a1, a2}, 3);
        chk(seen.size() == 1, "R5 strobe count", seen.size(), 1);
        if (seen.size() > 0) chk(seen[0] == {1'b1, 8'h21, 8'hC3}, "R5 strobe payload", seen[0], {1'b1, 8'h21, 8'hC3});
        seen.delete();

        // R6: command only
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h33, a1);
        bus_stop();
        chk(seen.size() == 1, "R6 strobe count", seen.size(), 1);
        if (seen.size() > 0) chk(seen[0] == {1'b0, 8'h33, 8'h00}, "R6 strobe payload", seen[0], {1'b0, 8'h33, 8'h00});
        seen.delete();

        // R3: mismatched strap pins
        pins = 2'b01;
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h21, a1);
        bus_stop();
        chk(!a0 && !a1, "R3 mismatch silent", {a0, a1}, 0);
        chk(seen.size() == 0, "R3 mismatch no strobe", seen.size(), 0);
        pins = 2'b10;

        // R7: read
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h85, a1);
        chk(a1, "R7 read command ack", a1, 1);
        chk(seen.size() == 1 && seen[0] == {1'b0, 8'h85, 8'h00}, "R7 read strobe", seen.size(), 1);
        recv_byte(rb, 1'b0);
        chk(rb == 8'hA6, "R7 read byte", rb, 8'hA6);
        recv_byte(rb, 1'b0);
        chk(rb == 8'hFF, "R7 released after byte", rb, 8'hFF);
        bus_stop();
        seen.delete();

        // R8: repeated start after a partial command
        bus_start();
        send_byte(8'h5A, a0);
        send_bits(8'h40, 4);
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h44, a1); send_byte(8'h12, a2);
        bus_stop();
        chk(a0 && a1 && a2, "R8 acks after restart", {a0, a1, a2}, 7);
        chk(seen.size() == 1, "R8 strobe count", seen.size(), 1);
        if (seen.size() > 0) chk(seen[0] == {1'b1, 8'h44, 8'h12}, "R8 strobe payload", seen[0], {1'b1, 8'h44, 8'h12});
        seen.delete();

        // R9: stop in the middle of the data byte
        bus_start();
        send_byte(8'h5A, a0); send_byte(8'h55, a1);
        send_bits(8'h90, 4);
        bus_stop();
        hp();
        chk(seen.size() == 0, "R9 abort no strobe", seen.size(), 0);
        chk(!sda_oe, "R9 abort released", sda_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule